// File: doc/BRIEF.md
# VLIW Execute Packet Dispatcher

The dispatcher sits between instruction fetch and the decode stages of a wide-issue core. It accepts one fetch packet of eight 32-bit instruction words at a time. It breaks each packet into execute packets, which are runs of words that issue in the same cycle. In every cycle it presents at most one execute packet on an eight-slot output bus, and each slot carries a valid flag.

Bit 0 of every instruction word chains that word to the one after it. A word whose chaining bit is clear closes the run. A mode input selects one of two rules at the end of a fetch packet. In the first, the run always closes at the last word of the packet. In the second, the run carries on into the leading words of the next packet, and the dispatcher waits for that packet when it has not yet arrived.

Top module: `vliw_dispatch`

## Requirements
- R1: A fetch packet on `fp_data` carries word i in bits [32i+31:32i], and word 0 comes first in program order. Bit 0 of each word is its chaining bit.
- R2: Each execute packet is a run of consecutive words that ends at the first word whose chaining bit is 0. Exactly one execute packet issues per cycle. For example, chaining bits 1,1,0,1,0,0,1,0 on words 0..7 issue as {0,1,2}, {3,4}, {5}, {6,7} on four consecutive cycles.
- R3: Issued words fill `slot_vld`/`slot_word` in program order from slot 0, so the valid flags form a contiguous run starting at bit 0. Slots that are not valid carry an all-zero word.
- R4: When `cross_en` is 0, the last word of a fetch packet closes the execute packet even if its chaining bit is 1.
- R5: When `cross_en` is 1 and the remaining words of the current packet are all chained, those words issue in one cycle together with the leading words of the incoming packet, up to and including its first word with chaining bit 0.
- R6: In that crossing case, if `fp_valid` is low, no slot is valid in that cycle and the held words stay pending.
- R7: No more than eight words issue in a cycle. In crossing mode, a chain longer than eight words is cut after the eighth word.
- R8: `fp_ready` is high only in three cases: when no packet is held, when the issuing execute packet takes the last held word, or when the dispatcher is waiting to cross. A packet is taken on a clock edge with `fp_valid` and `fp_ready` both high. It first issues in the following cycle unless it was taken by a crossing issue.
- R9: A synchronous active-high reset drops all held words, so the next cycle shows no valid slot and `fp_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cross_en | input | 1 | 1 lets an execute packet continue into the next fetch packet |
| fp_valid | input | 1 | A fetch packet is present on fp_data |
| fp_data | input | 256 | Eight instruction words, word 0 in the low bits |
| fp_ready | output | 1 | Dispatcher takes the presented packet at this edge |
| slot_vld | output | 8 | Valid flag per issue slot |
| slot_word | output | 256 | Issued words, slot 0 in the low bits |

## Verification
The bench builds the block with its defaults of eight words of 32 bits. This makes a single fetch packet as wide as the issue bus. It is therefore the width at which a fully chained packet fills every slot and a crossing chain reaches the eight-word cap. Both settings of `cross_en` are driven, and the mode is also switched randomly between cycles. This exercises the forced close at the packet end, the crossing issue, and the stall while the next packet is missing, each against chaining patterns that put the open run at every position.

// File: rtl/vliw_dispatch.sv
module vliw_dispatch #(
  parameter int N = 8,
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cross_en,
  input  logic           fp_valid,
  input  logic [N*W-1:0] fp_data,
  output logic           fp_ready,
  output logic [N-1:0]   slot_vld,
  output logic [N*W-1:0] slot_word
);
  localparam int PW = $clog2(N + 1);

  logic [N*W-1:0] cur;
  logic           cur_vld;
  logic [PW-1:0]  pos;
  logic           found;
  logic [PW-1:0]  ends;
  logic [PW-1:0]  lead;
  logic [PW-1:0]  cnt;
  logic           crossing;
  logic           last_in;
  logic           take;

  always_comb begin
    found = 1'b0;
    ends  = PW'(N - 1);
    for (int i = N - 1; i >= 0; i--)
      if (i >= int'(pos) && !cur[i*W]) begin
        found = 1'b1;
        ends  = PW'(i);
      end
    lead = pos;
    for (int j = N - 1; j >= 0; j--)
      if (j < int'(pos) && !fp_data[j*W]) lead = PW'(j + 1);
  end

  assign crossing = cur_vld && cross_en && !found;
  assign last_in  = cur_vld && !crossing && (ends == PW'(N - 1));
  assign fp_ready = !cur_vld || crossing || last_in;
  assign take     = fp_valid && fp_ready;

  always_comb begin
    if (!cur_vld)      cnt = '0;
    else if (!crossing) cnt = ends - pos + PW'(1);
    else if (fp_valid) cnt = PW'(N) - pos + lead;
    else               cnt = '0;
  end

  always_comb begin
    slot_vld  = '0;
    slot_word = '0;
    for (int s = 0; s < N; s++) begin
      if (s < int'(cnt)) begin
        slot_vld[s] = 1'b1;
        if (int'(pos) + s < N)
          slot_word[s*W +: W] = cur[(int'(pos) + s)*W +: W];
        else
          slot_word[s*W +: W] = fp_data[(int'(pos) + s - N)*W +: W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_vld <= 1'b0;
      pos     <= '0;
    end else if (take) begin
      cur     <= fp_data;
      cur_vld <= 1'b1;
      pos     <= crossing ? lead : '0;
    end else if (last_in) begin
      cur_vld <= 1'b0;
      pos     <= '0;
    end else if (cur_vld && !crossing) begin
      pos     <= ends + PW'(1);
    end
  end
endmodule

// File: rtl/vliw_dispatch_chk.sv
module vliw_dispatch_chk #(
  parameter int N = 8,
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           cross_en,
  input logic           fp_valid,
  input logic           fp_ready,
  input logic [N-1:0]   slot_vld,
  input logic [N*W-1:0] slot_word
);
  // R3
  slots_contig_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_vld & (slot_vld + 1'b1)) == '0);

  // R8
  idle_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_vld == '0) |-> fp_ready);

  // R4
  nocross_issue_chk: assert property (@(posedge clk) disable iff (rst)
    (fp_valid && fp_ready) |=> (cross_en || slot_vld != '0));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (slot_vld == '0 && fp_ready));

  generate
    for (genvar s = 0; s < N - 1; s++) begin : g_chain
      // R2
      chain_bit_chk: assert property (@(posedge clk) disable iff (rst)
        slot_vld[s+1] |-> slot_word[s*W]);
    end
  endgenerate
endmodule

bind vliw_dispatch vliw_dispatch_chk #(.N(N), .W(W)) u_chk (
  .clk(clk), .rst(rst), .cross_en(cross_en), .fp_valid(fp_valid),
  .fp_ready(fp_ready), .slot_vld(slot_vld), .slot_word(slot_word)
);

// File: tb/vliw_dispatch_tb.sv
`timescale 1ns/1ps
module vliw_dispatch_tb;
  localparam int N = 8;
  localparam int W = 32;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           cross_en = 1'b0;
  logic           fp_valid = 1'b0;
  logic [N*W-1:0] fp_data = '0;
  logic           fp_ready;
  logic [N-1:0]   slot_vld;
  logic [N*W-1:0] slot_word;

  int checks = 0;
  int fails  = 0;
  string tag = "R9";
  logic [W-1:0] pend[$];
  int pkt_id = 0;

  always #2.5 clk = ~clk;

  vliw_dispatch #(.N(N), .W(W)) u_dut (
    .clk(clk), .rst(rst), .cross_en(cross_en), .fp_valid(fp_valid),
    .fp_data(fp_data), .fp_ready(fp_ready), .slot_vld(slot_vld),
    .slot_word(slot_word)
  );

  function automatic logic [N*W-1:0] mk(input logic [N-1:0] pb);
    logic [N*W-1:0] d;
    for (int i = 0; i < N; i++)
      d[i*W +: W] = {24'(pkt_id * N + i), 7'h0, pb[i]};
    pkt_id++;
    return d;
  endfunction

  task automatic step(input bit v, input logic [N*W-1:0] d, input bit cr);
    logic [W-1:0] iss[$];
    logic [W-1:0] nq[$];
    logic [N-1:0] ev;
    logic [N*W-1:0] ew;
    bit rdy;
    bit endf;
    @(negedge clk);
    fp_valid = v; fp_data = d; cross_en = cr;
    #1;
    if (rst) begin
      pend.delete();
      return;
    end
    rdy = 1'b0;
    if (pend.size() == 0) begin
      rdy = 1'b1;
      if (v) for (int i = 0; i < N; i++) pend.push_back(d[i*W +: W]);
    end else begin
      endf = 1'b0;
      foreach (pend[t]) begin
        iss.push_back(pend[t]);
        if (!pend[t][0]) begin endf = 1'b1; break; end
      end
      if (endf || !cr) begin
        for (int k = 0; k < iss.size(); k++) void'(pend.pop_front());
        rdy = (pend.size() == 0);
        if (rdy && v) for (int i = 0; i < N; i++) pend.push_back(d[i*W +: W]);
      end else begin
        rdy = 1'b1;
        if (v) begin
          pend.delete();
          for (int i = 0; i < N; i++) nq.push_back(d[i*W +: W]);
          while (iss.size() < N) begin
            logic [W-1:0] w;
            w = nq.pop_front();
            iss.push_back(w);
            if (!w[0]) break;
          end
          pend = nq;
        end else iss.delete();
      end
    end
    ev = '0; ew = '0;
    foreach (iss[s]) begin ev[s] = 1'b1; ew[s*W +: W] = iss[s]; end
    checks++;
    if (slot_vld !== ev || slot_word !== ew) begin
      fails++;
      $display("FAIL %s slots: act vld=%b word=%h exp vld=%b word=%h",
               tag, slot_vld, slot_word, ev, ew);
    end
    checks++;
    if (fp_ready !== rdy) begin
      fails++;
      $display("FAIL R8 (%s) fp_ready: act %b exp %b", tag, fp_ready, rdy);
    end
  endtask

  task automatic idle(input int n, input bit cr);
    for (int i = 0; i < n; i++) step(1'b0, '0, cr);
  endtask

  initial begin
    #(200000 * 5.0);
    fails++;
    $display("FAIL watchdog: act running exp finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    step(1'b0, '0, 1'b0);
    step(1'b0, '0, 1'b0);
    rst = 1'b0;
    tag = "R9 reset state";
    idle(1, 1'b0);

    tag = "R1/R2 example order";
    step(1'b1, mk(8'b0100_1011), 1'b0);
    idle(5, 1'b0);

    tag = "R4 forced close";
    step(1'b1, mk(8'hFF), 1'b0);
    idle(2, 1'b0);
    step(1'b1, mk(8'b1110_0000), 1'b0);
    idle(7, 1'b0);

    tag = "R3 slot order";
    step(1'b1, mk(8'b0111_1110), 1'b0);
    idle(4, 1'b0);

    tag = "R6 crossing stall";
    step(1'b1, mk(8'b1100_0000), 1'b1);
    idle(6, 1'b1);
    idle(2, 1'b1);
    tag = "R5 crossing issue";
    step(1'b1, mk(8'b1111_1101), 1'b1);
    idle(8, 1'b1);

    tag = "R7 eight-word cap";
    step(1'b1, mk(8'b1111_1100), 1'b1);
    idle(2, 1'b1);
    step(1'b1, mk(8'hFF), 1'b1);
    step(1'b1, mk(8'h00), 1'b1);
    idle(10, 1'b1);

    tag = "R9 reset mid-stream";
    step(1'b1, mk(8'b1010_1010), 1'b0);
    idle(1, 1'b0);
    rst = 1'b1;
    idle(1, 1'b0);
    rst = 1'b0;
    idle(2, 1'b0);

    tag = "R2/R5 random stream";
    for (int c = 0; c < 3000; c++)
      step(1'($urandom_range(0, 1)), mk(N'($urandom())), 1'($urandom_range(0, 1)));
    idle(10, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule